// File: doc/BRIEF.md
# Mouse Movement Packet Receiver

This block listens to the two lines a pointing device drives, a clock and a data line. It resynchronizes both to the system clock and filters out short glitches. It takes one bit on each falling edge of the filtered device clock. Bits are grouped into 11-bit frames. Each frame is checked for its start bit, stop bit and odd parity. Checked bytes are then collected into four-byte movement packets. The first byte of every packet must have its always-one marker bit set; a byte that lacks it is skipped, so the packet boundary locks onto the next byte.

A packet is presented to the processor only when all four bytes have arrived without fault. It sits in one 32-bit register behind a ready flag. A single read strobe consumes the packet: it clears the data, the flag and the overrun indication together. A processor that acts only on the flag can never pull a partial, repeated or shifted packet. A frame fault drops the whole packet being built. If the device clock stalls in mid-byte or mid-packet, the partial state is abandoned. No error correction is tried.

Top module: `mouse_pkt_rx`

## Requirements
- R1: After reset, `pktReady` is 0, `pktOverrun` is 0 and `pktData` is zero.
- R2: A frame is 11 bits, taken on falling edges of `devClk`, in this order: start bit, then 8 data bits LSB first, then parity, then stop. Four good bytes set `pktReady`, and `pktData` holds them as byte0 in [7:0], byte1 in [15:8], byte2 in [23:16] and byte3 (wheel) in [31:24].
- R3: A one-cycle `rdEn` clears `pktReady`, `pktOverrun` and `pktData` on the next clock. While `pktReady` is 0, `pktData` is zero.
- R4: The parity bit must make the count of ones over the 8 data bits plus parity odd. A byte that fails this discards the whole packet being built, and the next byte starts a new packet.
- R5: A start bit of 1 or a stop bit of 0 is a framing error with the same effect as R4.
- R6: If a byte arrives as the first of a packet with data bit 3 equal to 0, it is discarded, and the next byte is taken as the first byte.
- R7: If a packet completes while `pktReady` is still 1, the new packet replaces the old one and `pktOverrun` is set until a read.
- R8: If no falling edge arrives for `TIMEOUT_CYC` cycles while a byte or packet is partly received, the bit and byte counts return to zero and the partial packet is discarded.
- R9: A level on `devClk` or `devDat` must hold for `FILT_LEN` consecutive synchronized samples before the receiver sees it, so a shorter clock glitch causes no bit to be taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| devClk | input | 1 | Clock line driven by the device, idle high |
| devDat | input | 1 | Data line driven by the device, idle high |
| rdEn | input | 1 | One-cycle strobe that consumes the current packet |
| pktData | output | 32 | Latched four-byte packet, zero when none is held |
| pktReady | output | 1 | A complete packet is waiting |
| pktOverrun | output | 1 | A packet was overwritten before it was read |

## Verification
The bench keeps the default `FILT_LEN` of 8, so 3-cycle clock glitches fall well below the filter length while 40-cycle half-bits pass it. It lowers `TIMEOUT_CYC` to 600 cycles. That puts a stalled two-byte partial packet within a short wait. A later packet then shows whether the stale bytes were dropped, since leftover bytes would make it complete early with shifted data.

// File: rtl/mouse_pkt_pkg.sv
package mouse_pkt_pkg;
  localparam int FRAME_BITS = 11;
  localparam int BYTE_W     = 8;
  localparam int PKT_BYTES  = 4;
  localparam int IDX_W      = $clog2(PKT_BYTES);
  localparam int PKT_W      = PKT_BYTES * BYTE_W;

  // strobes from control to datapath
  typedef struct packed {
    logic             sampleBit;
    logic             storeByte;
    logic [IDX_W-1:0] byteIdx;
    logic             commit;
  } rx_strobe_t;
endpackage

// File: rtl/mouse_pkt_dp.sv
module mouse_pkt_dp
  import mouse_pkt_pkg::*;
#(
  parameter int FILT_LEN = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  devClk,
  input  logic                  devDat,
  input  logic                  rdEn,
  input  rx_strobe_t            stb,
  output logic                  fallEdge,
  output logic [FRAME_BITS-1:0] frame,
  output logic [PKT_W-1:0]      pktData,
  output logic                  pktReady,
  output logic                  pktOverrun
);
  localparam int LINES = 2;

  logic [LINES-1:0] rawLines;
  logic [LINES-1:0] filtLines;
  assign rawLines = {devDat, devClk};

  // two-flop synchronizer plus all-same-sample filter per line
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [1:0]          syncQ;
    logic [FILT_LEN-1:0] histQ;
    logic                levelQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ  <= '1;
        histQ  <= '1;
        levelQ <= 1'b1;
      end else begin
        syncQ <= {syncQ[0], rawLines[g]};
        histQ <= {histQ[FILT_LEN-2:0], syncQ[1]};
        if (&histQ)       levelQ <= 1'b1;
        else if (~|histQ) levelQ <= 1'b0;
      end
    end
    assign filtLines[g] = levelQ;
  end

  logic clkPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkPrev <= 1'b1;
    else       clkPrev <= filtLines[0];
  end
  assign fallEdge = clkPrev && !filtLines[0];

  // frame shifter: first bit ends in frame[0]
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              frame <= '0;
    else if (stb.sampleBit) frame <= {filtLines[1], frame[FRAME_BITS-1:1]};
  end

  logic [BYTE_W-1:0] partBytes [PKT_BYTES-1];
  logic [PKT_W-1:0]  assembled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PKT_BYTES - 1; i++) partBytes[i] <= '0;
    end else if (stb.storeByte) begin
      partBytes[stb.byteIdx] <= frame[BYTE_W:1];
    end
  end

  always_comb begin
    for (int i = 0; i < PKT_BYTES - 1; i++) assembled[i*BYTE_W +: BYTE_W] = partBytes[i];
    assembled[(PKT_BYTES-1)*BYTE_W +: BYTE_W] = frame[BYTE_W:1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktData    <= '0;
      pktReady   <= 1'b0;
      pktOverrun <= 1'b0;
    end else if (stb.commit) begin
      pktData    <= assembled;
      pktReady   <= 1'b1;
      pktOverrun <= pktReady && !rdEn;
    end else if (rdEn) begin
      pktData    <= '0;
      pktReady   <= 1'b0;
      pktOverrun <= 1'b0;
    end
  end

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && !stb.commit |=> !pktReady && pktData == '0 && !pktOverrun); // R3
  AST_EMPTY_IS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !pktReady |-> pktData == '0 && !pktOverrun); // R3
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit && pktReady && !rdEn |=> pktReady && pktOverrun); // R7
endmodule

// File: rtl/mouse_pkt_ctl.sv
module mouse_pkt_ctl
  import mouse_pkt_pkg::*;
#(
  parameter int TIMEOUT_CYC = 200000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  fallEdge,
  input  logic [FRAME_BITS-1:0] frame,
  output rx_strobe_t            stb
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam int IDL_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_BYTES - 1);
  localparam logic [IDL_W-1:0] IDL_MAX  = IDL_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] bitCnt;
  logic [IDX_W-1:0] byteCnt;
  logic [IDL_W-1:0] idleCnt;
  logic             evalNow;
  logic             frameOk, headOk, busy, expire;

  assign frameOk = !frame[0] && frame[FRAME_BITS-1] && (^frame[BYTE_W+1:1]);
  assign headOk  = frame[4];   // data bit 3
  assign busy    = (bitCnt != '0) || (byteCnt != '0);
  assign expire  = busy && !fallEdge && (idleCnt == IDL_MAX);

  always_comb begin
    stb.sampleBit = fallEdge;
    stb.byteIdx   = byteCnt;
    stb.storeByte = evalNow && frameOk && (byteCnt != LAST_IDX) &&
                    ((byteCnt != '0) || headOk);
    stb.commit    = evalNow && frameOk && (byteCnt == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      byteCnt <= '0;
      idleCnt <= '0;
      evalNow <= 1'b0;
    end else begin
      evalNow <= 1'b0;
      if (fallEdge) begin
        idleCnt <= '0;
        if (bitCnt == LAST_BIT) begin
          bitCnt  <= '0;
          evalNow <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end else if (busy) begin
        idleCnt <= expire ? '0 : idleCnt + 1'b1;
      end else begin
        idleCnt <= '0;
      end

      if (evalNow) begin
        if (!frameOk || byteCnt == LAST_IDX) byteCnt <= '0;
        else if (byteCnt == '0 && !headOk)   byteCnt <= '0;
        else                                 byteCnt <= byteCnt + 1'b1;
      end

      if (expire) begin
        bitCnt  <= '0;
        byteCnt <= '0;
      end
    end
  end

  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_BIT); // R2
  AST_BAD_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    evalNow && !frameOk |=> byteCnt == '0); // R4
  AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt <= IDL_MAX); // R8
  AST_STALL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> bitCnt == '0 && byteCnt == '0); // R8
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.storeByte && stb.commit)); // R2
endmodule

// File: rtl/mouse_pkt_rx.sv
module mouse_pkt_rx
  import mouse_pkt_pkg::*;
#(
  parameter int FILT_LEN    = 8,
  parameter int TIMEOUT_CYC = 200000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             devClk,
  input  logic             devDat,
  input  logic             rdEn,
  output logic [PKT_W-1:0] pktData,
  output logic             pktReady,
  output logic             pktOverrun
);
  rx_strobe_t            stb;
  logic                  fallEdge;
  logic [FRAME_BITS-1:0] frame;

  mouse_pkt_dp #(.FILT_LEN(FILT_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .devClk(devClk), .devDat(devDat), .rdEn(rdEn),
    .stb(stb), .fallEdge(fallEdge), .frame(frame),
    .pktData(pktData), .pktReady(pktReady), .pktOverrun(pktOverrun)
  );

  mouse_pkt_ctl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctl (
    .clk(clk), .rstN(rstN), .fallEdge(fallEdge), .frame(frame), .stb(stb)
  );
endmodule

// File: tb/mouse_pkt_rx_bench.sv
module mouse_pkt_rx_bench;
  localparam int HALF = 40;
  localparam int TOUT = 600;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        devClk = 1'b1;
  logic        devDat = 1'b1;
  logic        rdEn = 1'b0;
  logic [31:0] pktData;
  logic        pktReady, pktOverrun;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  mouse_pkt_rx #(.FILT_LEN(8), .TIMEOUT_CYC(TOUT)) u_mouse_pkt_rx (
    .clk(clk), .rstN(rstN), .devClk(devClk), .devDat(devDat), .rdEn(rdEn),
    .pktData(pktData), .pktReady(pktReady), .pktOverrun(pktOverrun)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic flipPar,
                           input logic startV, input logic stopV);
    logic [10:0] bits;
    bits = {stopV, (~^d) ^ flipPar, d, startV};
    for (int i = 0; i < 11; i++) begin
      devDat = bits[i];
      waitCyc(HALF);
      devClk = 1'b0;
      waitCyc(HALF);
      devClk = 1'b1;
    end
    devDat = 1'b1;
    waitCyc(150);
  endtask

  task automatic goodByte(input logic [7:0] d);
    sendFrame(d, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic sendPkt(input logic [31:0] p);
    for (int i = 0; i < 4; i++) goodByte(p[i*8 +: 8]);
    waitCyc(30);
  endtask

  task automatic expectPkt(input string req, input logic [31:0] p, input logic ovr);
    @(negedge clk);
    check({req, " ready"}, 32'(pktReady), 32'd1);
    check({req, " data"}, pktData, p);
    check({req, " overrun"}, 32'(pktOverrun), 32'(ovr));
  endtask

  task automatic doRead();
    waitCyc(1);
    rdEn = 1'b1;
    waitCyc(1);
    rdEn = 1'b0;
    waitCyc(2);
  endtask

  task automatic expectEmpty(input string req);
    @(negedge clk);
    check({req, " ready clear"}, 32'(pktReady), 32'd0);
    check({req, " data clear"}, pktData, 32'd0);
    check({req, " overrun clear"}, 32'(pktOverrun), 32'd0);
  endtask

  task automatic t_reset();
    expectEmpty("R1");
  endtask

  task automatic t_basic();
    sendPkt(32'h01FB0518);
    expectPkt("R2 pattern A", 32'h01FB0518, 1'b0);
    doRead();
    expectEmpty("R3 after read");
    sendPkt(32'hFF7F802C);
    expectPkt("R2 pattern B", 32'hFF7F802C, 1'b0);
    doRead();
    expectEmpty("R3 second read");
  endtask

  task automatic t_parity();
    goodByte(8'h08);
    sendFrame(8'h11, 1'b1, 1'b0, 1'b1);
    waitCyc(20);
    @(negedge clk);
    check("R4 no ready after parity fault", 32'(pktReady), 32'd0);
    sendPkt(32'hF0332209);
    expectPkt("R4 realigned", 32'hF0332209, 1'b0);
    doRead();
  endtask

  task automatic t_framing();
    goodByte(8'h08);
    sendFrame(8'h44, 1'b0, 1'b0, 1'b0);
    sendPkt(32'h12345678);
    expectPkt("R5 bad stop", 32'h12345678, 1'b0);
    doRead();
    goodByte(8'h08);
    goodByte(8'h21);
    sendFrame(8'h55, 1'b0, 1'b1, 1'b1);
    sendPkt(32'hABCDEF0A);
    expectPkt("R5 bad start", 32'hABCDEF0A, 1'b0);
    doRead();
  endtask

  task automatic t_header();
    goodByte(8'h00);
    goodByte(8'hF7);
    sendPkt(32'h03020118);
    expectPkt("R6 header resync", 32'h03020118, 1'b0);
    doRead();
  endtask

  task automatic t_overrun();
    sendPkt(32'h11223348);
    sendPkt(32'h55667788);
    expectPkt("R7 overwrite", 32'h55667788, 1'b1);
    doRead();
    expectEmpty("R7 read clears");
  endtask

  task automatic t_timeout();
    goodByte(8'h08);
    goodByte(8'h99);
    waitCyc(TOUT + 200);
    sendPkt(32'h0D0C0B0A);
    expectPkt("R8 stall discard", 32'h0D0C0B0A, 1'b0);
    doRead();
    // stall in mid-byte
    devDat = 1'b0;
    waitCyc(HALF);
    devClk = 1'b0;
    waitCyc(HALF);
    devClk = 1'b1;
    devDat = 1'b1;
    waitCyc(TOUT + 200);
    sendPkt(32'h4433221C);
    expectPkt("R8 mid-byte stall", 32'h4433221C, 1'b0);
    doRead();
  endtask

  task automatic t_glitch();
    goodByte(8'h28);
    devClk = 1'b0;
    waitCyc(3);
    devClk = 1'b1;
    waitCyc(100);
    goodByte(8'h81);
    devClk = 1'b0;
    waitCyc(5);
    devClk = 1'b1;
    waitCyc(100);
    goodByte(8'h42);
    goodByte(8'h00);
    waitCyc(30);
    expectPkt("R9 glitch ignored", 32'h00428128, 1'b0);
    doRead();
  endtask

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(5);
    t_reset();
    t_basic();
    t_parity();
    t_framing();
    t_header();
    t_overrun();
    t_timeout();
    t_glitch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule